// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose I/O Port

This block is a 32-pin general-purpose I/O port that a processor reaches through a small word-addressed register bus. Each pin can be set as an input or an output. The port keeps an output value latch and a direction latch. It passes every incoming pin through a two-stage synchronizer before it uses the value.

Each pin has a two-bit detection mode that selects one of four conditions: low level, high level, rising edge or falling edge. The modes of pins 0 to 15 sit in one configuration word, and the modes of pins 16 to 31 sit in the next word up. A detected condition sets a sticky pending bit. Software clears a pending bit by writing a one to it. A separate enable mask decides which pending bits drive the single interrupt line. The bus reads combinationally and writes on the clock edge when the write enable is high.

Top module: `gpio_irq_port`

## Requirements
- R1: While reset is held and on the first cycle after it, the mask and pending words read zero, `pin_oe` and `pin_out` are zero, and `irq` is low. Both mode words read all ones, which selects falling-edge mode, so a pin that is low at reset raises nothing.
- R2: A write to word 1 sets the direction, where 1 means output. From the next cycle `pin_oe` equals the written value. A write to word 0 sets the output latch, which appears on `pin_out` from the next cycle.
- R3: A read of word 0 returns, for each pin, the output latch bit when the pin is an output, and the synchronized input when the pin is an input. A change on `pin_in` becomes visible in this read after two clock edges.
- R4: Word 2 holds the modes of pins 0-15 and word 3 holds the modes of pins 16-31. Pin n uses bits [2*(n mod 16)+1 : 2*(n mod 16)] of its word. Both words read back what was written.
- R5: The mode codes are 00 low level, 01 high level, 10 rising edge and 11 falling edge. An edge is found by comparing the synchronized value with its value one cycle earlier. A pending bit (word 5) is set on the third clock edge after the pin change that causes it.
- R6: A pin in a level mode sets its pending bit on every cycle that the level persists, so a clear does not remove the bit while the level holds.
- R7: A write to word 5 clears each pending bit written with 1 and leaves each bit written with 0 unchanged. If a new event and a clear reach the same bit in the same cycle, the bit stays set.
- R8: Word 4 is the enable mask, where 1 enables a pin. Pending bits are set whatever the mask says. `irq` is high exactly when pending AND mask is nonzero.
- R9: Words 6 and 7 read zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Word address |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the word at `bus_addr` |
| pin_in | input | 32 | Pin input levels |
| pin_out | output | 32 | Output latch values |
| pin_oe | output | 32 | Output enables, 1 = drive |
| irq | output | 1 | Interrupt request |

## Verification
The bench first uses fixed patterns. One is a single rising pin in rising mode. Another is a held low level in low-level mode, cleared in the same cycle that the level re-asserts; this separates a pending bit that stays sticky from one that re-sets. Another is a masked pin that collects a pending bit and then raises `irq` only once it is unmasked.

A long random phase follows. In it, pin toggles, mode rewrites, mask changes, partial clears and writes to unused words are mixed at random, and they often land in the same cycle. This exposes any wrong order between detection, clearing and bus writes, and any off-by-one in the synchronizer latency. A reference model checks every output and the read port on each cycle.

// File: rtl/gpio_irq_port.sv
module gpio_irq_port #(
  parameter int NPIN = 32,
  parameter int AW   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_we,
  input  logic [NPIN-1:0] bus_wdata,
  output logic [NPIN-1:0] bus_rdata,
  input  logic [NPIN-1:0] pin_in,
  output logic [NPIN-1:0] pin_out,
  output logic [NPIN-1:0] pin_oe,
  output logic            irq
);
  localparam int HALF = NPIN / 2;
  localparam logic [AW-1:0] A_DATA = AW'(0);
  localparam logic [AW-1:0] A_DIR  = AW'(1);
  localparam logic [AW-1:0] A_CLO  = AW'(2);
  localparam logic [AW-1:0] A_CHI  = AW'(3);
  localparam logic [AW-1:0] A_MASK = AW'(4);
  localparam logic [AW-1:0] A_STAT = AW'(5);

  logic [NPIN-1:0] data_q, dir_q, cfg_lo_q, cfg_hi_q, mask_q, stat_q;
  logic [NPIN-1:0] sync1_q, sync2_q, prev_q, evt;

  wire wr_data = bus_we && bus_addr == A_DATA;
  wire wr_dir  = bus_we && bus_addr == A_DIR;
  wire wr_clo  = bus_we && bus_addr == A_CLO;
  wire wr_chi  = bus_we && bus_addr == A_CHI;
  wire wr_mask = bus_we && bus_addr == A_MASK;
  wire wr_stat = bus_we && bus_addr == A_STAT;

  for (genvar i = 0; i < NPIN; i++) begin : g_det
    logic [1:0] mode;
    if (i < HALF) begin : g_lo
      assign mode = cfg_lo_q[2*i +: 2];
    end else begin : g_hi
      assign mode = cfg_hi_q[2*(i-HALF) +: 2];
    end
    always_comb begin
      unique case (mode)
        2'b00: evt[i] = ~sync2_q[i];
        2'b01: evt[i] =  sync2_q[i];
        2'b10: evt[i] =  sync2_q[i] & ~prev_q[i];
        default: evt[i] = ~sync2_q[i] & prev_q[i];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q   <= '0;
      dir_q    <= '0;
      cfg_lo_q <= '1;
      cfg_hi_q <= '1;
      mask_q   <= '0;
      stat_q   <= '0;
    end else begin
      if (wr_data) data_q   <= bus_wdata;
      if (wr_dir)  dir_q    <= bus_wdata;
      if (wr_clo)  cfg_lo_q <= bus_wdata;
      if (wr_chi)  cfg_hi_q <= bus_wdata;
      if (wr_mask) mask_q   <= bus_wdata;
      stat_q <= (stat_q & ~(wr_stat ? bus_wdata : '0)) | evt;
    end
  end

  always_comb begin
    unique case (bus_addr)
      A_DATA:  bus_rdata = (data_q & dir_q) | (sync2_q & ~dir_q);
      A_DIR:   bus_rdata = dir_q;
      A_CLO:   bus_rdata = cfg_lo_q;
      A_CHI:   bus_rdata = cfg_hi_q;
      A_MASK:  bus_rdata = mask_q;
      A_STAT:  bus_rdata = stat_q;
      default: bus_rdata = '0;
    endcase
  end

  assign pin_out = data_q;
  assign pin_oe  = dir_q;
  assign irq     = |(stat_q & mask_q);
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk #(
  parameter int NPIN = 32,
  parameter int AW   = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic [AW-1:0]   bus_addr,
  input logic            bus_we,
  input logic [NPIN-1:0] bus_wdata,
  input logic [NPIN-1:0] pin_out,
  input logic [NPIN-1:0] pin_oe,
  input logic            irq,
  input logic [NPIN-1:0] stat_q,
  input logic [NPIN-1:0] mask_q,
  input logic [NPIN-1:0] evt
);
  a_r1_quiet_in_reset: assert property (@(posedge clk) !rst_n |-> (!irq && pin_oe == '0));

  a_r2_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'(1)) |=> pin_oe == $past(bus_wdata));

  a_r2_data_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'(0)) |=> pin_out == $past(bus_wdata));

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_addr == AW'(5)) |=> (stat_q & $past(stat_q)) == $past(stat_q));

  a_r7_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> (stat_q & $past(evt)) == $past(evt));

  a_r8_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq);
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.NPIN(NPIN), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq),
  .stat_q(stat_q), .mask_q(mask_q), .evt(evt)
);

// File: tb/test_gpio_irq_port.sv
`timescale 1ns/1ps
module test_gpio_irq_port;
  logic        clk = 0, rst_n = 0, bus_we = 0, irq;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, pin_in = '0, pin_out, pin_oe;
  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_irq_port i_gpio_irq_port (.*);

  logic [31:0] m_data, m_dir, m_clo, m_chi, m_mask, m_stat, h0, h1, h2;

  function automatic logic [1:0] mode_of(int p);
    return p < 16 ? m_clo[2*p +: 2] : m_chi[2*(p-16) +: 2];
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_data = 0; m_dir = 0; m_clo = '1; m_chi = '1; m_mask = 0; m_stat = 0;
      h0 = 0; h1 = 0; h2 = 0;
    end else begin
      logic [31:0] ev;
      for (int p = 0; p < 32; p++)
        case (mode_of(p))
          2'b00: ev[p] = !h1[p];
          2'b01: ev[p] = h1[p];
          2'b10: ev[p] = h1[p] && !h2[p];
          default: ev[p] = !h1[p] && h2[p];
        endcase
      m_stat = (m_stat & ~((bus_we && bus_addr == 5) ? bus_wdata : 32'h0)) | ev;
      if (bus_we)
        case (bus_addr)
          0: m_data = bus_wdata;
          1: m_dir  = bus_wdata;
          2: m_clo  = bus_wdata;
          3: m_chi  = bus_wdata;
          4: m_mask = bus_wdata;
          default: ;
        endcase
      h2 = h1; h1 = h0; h0 = pin_in;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    logic [31:0] er;
    string tag;
    case (bus_addr)
      0: begin er = (m_data & m_dir) | (h1 & ~m_dir); tag = "R3 data read"; end
      1: begin er = m_dir;  tag = "R2 dir read"; end
      2: begin er = m_clo;  tag = "R4 mode lo read"; end
      3: begin er = m_chi;  tag = "R4 mode hi read"; end
      4: begin er = m_mask; tag = "R8 mask read"; end
      5: begin er = m_stat; tag = "R5/R7 pending read"; end
      default: begin er = 0; tag = "R9 unused read"; end
    endcase
    chk(tag, bus_rdata, er);
    chk("R2 pin_out", pin_out, m_data);
    chk("R2 pin_oe", pin_oe, m_dir);
    chk("R8 irq", {31'b0, irq}, {31'b0, |(m_stat & m_mask)});
  end

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(posedge clk); #1; bus_addr = a; bus_wdata = d; bus_we = 1;
    @(posedge clk); #1; bus_we = 0;
  endtask

  task automatic sel(logic [2:0] a);
    @(posedge clk); #1; bus_addr = a;
  endtask

  task automatic rd_chk(logic [2:0] a, logic [31:0] exp, string tag);
    sel(a); #1; chk(tag, bus_rdata, exp);
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    wait (cyc > 50000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    #1;
    bus_addr = 4; #1; chk("R1 mask at reset", bus_rdata, 0);
    bus_addr = 5; #1; chk("R1 pending at reset", bus_rdata, 0);
    bus_addr = 2; #1; chk("R1 mode lo at reset", bus_rdata, 32'hFFFF_FFFF);
    chk("R1 oe at reset", pin_oe, 0);
    chk("R1 irq at reset", {31'b0, irq}, 0);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);
    rd_chk(5, 0, "R1 pending stays clear with low pins");

    wr(1, 32'h0000_FFFF);
    wr(0, 32'hA5A5_1234);
    chk("R2 oe after write", pin_oe, 32'h0000_FFFF);
    pin_in = 32'h5A5A_0000;
    repeat (3) @(posedge clk);
    rd_chk(0, 32'h5A5A_1234, "R3 mixed data read");

    pin_in = 0;
    wr(2, 32'h0000_0080);
    wr(3, 32'h4000_0000);
    rd_chk(2, 32'h0000_0080, "R4 lo readback");
    rd_chk(3, 32'h4000_0000, "R4 hi readback");
    repeat (4) @(posedge clk);
    wr(5, '1);
    wr(4, 32'h0000_0008);
    @(posedge clk); #1; pin_in[3] = 1;
    repeat (3) @(posedge clk);
    #1 chk("R5 rising pin3 pending", bus_rdata & 32'h0000_0008, 32'h0000_0008);
    chk("R8 irq on enabled pin3", {31'b0, irq}, 1);

    wr(3, 32'h5000_0000);
    @(posedge clk); #1; pin_in[30] = 1;
    repeat (4) @(posedge clk);
    rd_chk(5, i_pending_expect(), "R8 masked pin30 pending");
    wr(4, 32'h4000_0000);
    wr(5, 32'h0000_0008);
    #1 chk("R8 irq from pin30 after unmask", {31'b0, irq}, 1);

    wr(2, 32'hFFFF_FFFC);
    repeat (4) @(posedge clk);
    wr(5, 32'h0000_0001);
    rd_chk(5, i_pending_expect() | 32'h1, "R6 R7 low level re-sets after clear");
    wr(5, 32'h0);
    wr(6, 32'hFFFF_FFFF);
    wr(7, 32'hFFFF_FFFF);
    rd_chk(6, 0, "R9 word 6 reads zero");
    rd_chk(1, 32'h0000_FFFF, "R9 dir unchanged by unused writes");

    for (int k = 0; k < 3000; k++) begin
      @(posedge clk); #1;
      pin_in = pin_in ^ ($urandom() & $urandom());
      bus_addr = 3'($urandom());
      bus_we = ($urandom() % 3) == 0;
      bus_wdata = $urandom();
    end
    @(posedge clk); #1; bus_we = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    finish_run();
  end

  function automatic logic [31:0] i_pending_expect();
    return m_stat;
  endfunction
endmodule